// File: doc/BRIEF.md
# Full-Map Home Directory Controller

This block is the home-node coherence controller for a small group of memory blocks that several processor nodes cache. Each block has a directory entry: one presence bit per node and a dirty flag. From these the block is uncached, clean-shared or dirty. Nodes send read misses and write misses on a request channel. The controller answers from its own copy of memory, or it redirects the requester to the node that holds the only valid copy. Before it gives out exclusive ownership, it invalidates the other sharers.

Each node has its own outbound message lane, so one cycle can carry different messages to different nodes. One pending transaction at a time waits for acknowledgements on a single acknowledgement channel. This can be an invalidation round or a forward to an owner. While it is pending, its block is busy. A request that touches the busy block is refused with a retry message. A request that would need a second pending transaction is also refused. Requests that can be answered at once still go through for other blocks.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every block is uncached and clean, block b holds the value INIT_BASE+b, and every lane carries message code 0 (none).
- R2: A read miss to a clean or uncached block returns code 1 (data) to the requester in the cycle after the request, carrying the home copy. The requester is then recorded as present.
- R3: A write miss to a clean block that no other node holds returns code 2 (grant) with the home copy in the next cycle. Afterwards only the writer is present and the block is dirty: a later read by another node is directed to the writer.
- R4: A write miss to a clean block with other sharers sends code 6 (invalidate) to every other present node in one cycle, with the peer field set to the writer. The writer receives nothing until the cycle after the last expected acknowledgement, when it gets code 2 with the home copy. Repeated acknowledgements and acknowledgements from nodes not asked are ignored.
- R5: The number of outstanding acknowledgements is loaded with the count of sharers other than the requester. It falls by one for each distinct expected acknowledgement, and the grant follows only when it reaches zero.
- R6: A read miss to a block dirty at another node sends code 3 (owner) to the requester with the peer field set to the owner, and code 4 (forward read) to the owner with the peer field set to the requester. The owner's acknowledgement carries the block data. That data is written to home memory, the block becomes clean, and both the owner and the requester are marked present.
- R7: A write miss to a block dirty at another node sends code 5 (recall) to the owner. The owner's acknowledgement data is written home and sent to the writer with code 2 in the next cycle. The writer becomes sole owner.
- R8: A request from the node that already owns a dirty block gets code 2 at once, and the directory entry is unchanged.
- R9: A request to a block with a pending transaction gets code 7 (retry) in the next cycle. So does any request that would start a second pending transaction. Neither changes the directory.
- R10: While a transaction is pending, requests to other blocks that need no acknowledgements are answered normally.
- R11: A dirty block always has exactly one presence bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_node_i | input | ID_W | Requesting node |
| req_blk_i | input | BLK_W | Requested block |
| req_excl_i | input | 1 | 1 for a write miss, 0 for a read miss |
| ack_valid_i | input | 1 | Acknowledgement present this cycle |
| ack_node_i | input | ID_W | Acknowledging node |
| ack_data_i | input | DATA_W | Block data returned by an owner |
| msg_type_o | output | N_NODES x 3 | Per-node message code, 0 = none |
| msg_blk_o | output | N_NODES x BLK_W | Per-node block index |
| msg_peer_o | output | N_NODES x ID_W | Per-node peer: the requester, or the owner for code 3 |
| msg_data_o | output | N_NODES x DATA_W | Per-node data, meaningful for codes 1 and 2 |

## Verification
The assertions assume that a node with a request still in flight sends no further request. They also assume at most one acknowledgement per cycle, and that an owner's acknowledgement carries the current block data. Under these assumptions, a completion grant and a fresh reply never target the same lane in the same cycle. The stimulus keeps within these limits by issuing one request or one acknowledgement at a time. It never lets a waiting writer or reader speak before its transaction closes. Acknowledgements from nodes that were never asked, and repeated ones, are sent on purpose.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [2:0] {
    MSG_NONE   = 3'd0,
    MSG_DATA   = 3'd1,
    MSG_GRANT  = 3'd2,
    MSG_OWNER  = 3'd3,
    MSG_FWD_RD = 3'd4,
    MSG_RECALL = 3'd5,
    MSG_INV    = 3'd6,
    MSG_NACK   = 3'd7
  } msg_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_NACK,
    ACT_DATA,
    ACT_GRANT,
    ACT_OWN_HIT,
    ACT_INV,
    ACT_FWD_RD,
    ACT_RECALL
  } act_e;

endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int N_NODES   = 4,
  parameter int N_BLOCKS  = 8,
  parameter int DATA_W    = 16,
  parameter int INIT_BASE = 'h1000,
  parameter int BLK_W     = $clog2(N_BLOCKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BLK_W-1:0]   rd_a_blk_i,
  output logic [N_NODES-1:0] pres_a_o,
  output logic               dirty_a_o,
  output logic [DATA_W-1:0]  data_a_o,
  input  logic [BLK_W-1:0]   rd_b_blk_i,
  output logic [DATA_W-1:0]  data_b_o,
  input  logic               wr_a_en_i,
  input  logic [BLK_W-1:0]   wr_a_blk_i,
  input  logic [N_NODES-1:0] wr_a_pres_i,
  input  logic               wr_a_dirty_i,
  input  logic               wr_b_en_i,
  input  logic [BLK_W-1:0]   wr_b_blk_i,
  input  logic [N_NODES-1:0] wr_b_pres_i,
  input  logic               wr_b_dirty_i,
  input  logic               wr_b_data_en_i,
  input  logic [DATA_W-1:0]  wr_b_data_i
);

  logic [N_NODES-1:0] pres_q  [N_BLOCKS];
  logic               dirty_q [N_BLOCKS];
  logic [DATA_W-1:0]  data_q  [N_BLOCKS];

  logic a_blocked;
  assign a_blocked = wr_b_en_i && (wr_a_blk_i == wr_b_blk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BLOCKS; b++) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
        data_q[b]  <= DATA_W'(INIT_BASE + b);
      end
    end else begin
      // completion port wins; the busy check keeps both off one block
      if (wr_b_en_i) begin
        pres_q[wr_b_blk_i]  <= wr_b_pres_i;
        dirty_q[wr_b_blk_i] <= wr_b_dirty_i;
        if (wr_b_data_en_i) data_q[wr_b_blk_i] <= wr_b_data_i;
      end
      if (wr_a_en_i && !a_blocked) begin
        pres_q[wr_a_blk_i]  <= wr_a_pres_i;
        dirty_q[wr_a_blk_i] <= wr_a_dirty_i;
      end
    end
  end

  assign pres_a_o  = pres_q[rd_a_blk_i];
  assign dirty_a_o = dirty_q[rd_a_blk_i];
  assign data_a_o  = data_q[rd_a_blk_i];
  assign data_b_o  = data_q[rd_b_blk_i];

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_chk
    AST_DIRTY_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_q[b] |-> ($countones(pres_q[b]) == 1)) else $error("dirty block without single owner"); // R11
  end

endmodule

// File: rtl/dir_decide.sv
module dir_decide import dir_pkg::*; #(
  parameter int N_NODES = 4,
  parameter int ID_W    = $clog2(N_NODES)
) (
  input  logic               req_valid_i,
  input  logic [ID_W-1:0]    req_node_i,
  input  logic               req_excl_i,
  input  logic [N_NODES-1:0] pres_i,
  input  logic               dirty_i,
  input  logic               busy_i,
  input  logic               trk_free_i,
  output act_e               act_o,
  output logic [N_NODES-1:0] others_o,
  output logic [ID_W-1:0]    owner_o
);

  localparam logic [N_NODES-1:0] ONE = N_NODES'(1);

  assign others_o = pres_i & ~(ONE << req_node_i);

  always_comb begin
    owner_o = '0;
    for (int i = N_NODES - 1; i >= 0; i--) begin
      if (pres_i[i]) owner_o = ID_W'(i);
    end
  end

  always_comb begin
    act_o = ACT_IDLE;
    if (req_valid_i) begin
      if (busy_i) begin
        act_o = ACT_NACK;
      end else if (dirty_i) begin
        if (owner_o == req_node_i) act_o = ACT_OWN_HIT;
        else if (!trk_free_i)      act_o = ACT_NACK;
        else                       act_o = req_excl_i ? ACT_RECALL : ACT_FWD_RD;
      end else if (req_excl_i) begin
        if (others_o == '0)   act_o = ACT_GRANT;
        else if (!trk_free_i) act_o = ACT_NACK;
        else                  act_o = ACT_INV;
      end else begin
        act_o = ACT_DATA;
      end
    end
  end

endmodule

// File: rtl/dir_tracker.sv
module dir_tracker #(
  parameter int N_NODES = 4,
  parameter int ID_W    = $clog2(N_NODES),
  parameter int BLK_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BLK_W-1:0]   load_blk_i,
  input  logic [ID_W-1:0]    load_req_i,
  input  logic [N_NODES-1:0] load_mask_i,
  input  logic               load_excl_i,
  input  logic               load_flush_i,
  input  logic               ack_valid_i,
  input  logic [ID_W-1:0]    ack_node_i,
  output logic               valid_o,
  output logic [BLK_W-1:0]   blk_o,
  output logic [ID_W-1:0]    req_o,
  output logic [N_NODES-1:0] mask_o,
  output logic               excl_o,
  output logic               flush_o,
  output logic               done_o
);

  localparam int CNT_W = $clog2(N_NODES + 1);

  logic               valid_q, excl_q, flush_q;
  logic [BLK_W-1:0]   blk_q;
  logic [ID_W-1:0]    req_q;
  logic [N_NODES-1:0] mask_q, pend_q;
  logic [CNT_W-1:0]   cnt_q, load_cnt;
  logic               ack_hit;

  always_comb begin
    load_cnt = '0;
    for (int i = 0; i < N_NODES; i++) begin
      load_cnt = load_cnt + {{(CNT_W-1){1'b0}}, load_mask_i[i]};
    end
  end

  assign ack_hit = valid_q && ack_valid_i && pend_q[ack_node_i];
  assign done_o  = ack_hit && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      excl_q  <= 1'b0;
      flush_q <= 1'b0;
      blk_q   <= '0;
      req_q   <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      excl_q  <= load_excl_i;
      flush_q <= load_flush_i;
      blk_q   <= load_blk_i;
      req_q   <= load_req_i;
      mask_q  <= load_mask_i;
      pend_q  <= load_mask_i;
      cnt_q   <= load_cnt;
    end else if (ack_hit) begin
      pend_q[ack_node_i] <= 1'b0;
      cnt_q              <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign blk_o   = blk_q;
  assign req_o   = req_q;
  assign mask_o  = mask_q;
  assign excl_o  = excl_q;
  assign flush_o = flush_q;

  AST_CNT_EQ_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (cnt_q == CNT_W'($countones(pend_q)))) else $error("ack count off"); // R5
  AST_CNT_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ack_valid_i) |=> $stable(cnt_q)) else $error("count moved without ack"); // R5
  AST_LOAD_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_mask_i != '0)) else $error("empty wait set"); // R5
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_q) else $error("second transaction started"); // R9

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl import dir_pkg::*; #(
  parameter int N_NODES   = 4,
  parameter int N_BLOCKS  = 8,
  parameter int DATA_W    = 16,
  parameter int INIT_BASE = 'h1000,
  parameter int ID_W      = $clog2(N_NODES),
  parameter int BLK_W     = $clog2(N_BLOCKS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  input  logic [ID_W-1:0]                 req_node_i,
  input  logic [BLK_W-1:0]                req_blk_i,
  input  logic                            req_excl_i,
  input  logic                            ack_valid_i,
  input  logic [ID_W-1:0]                 ack_node_i,
  input  logic [DATA_W-1:0]               ack_data_i,
  output logic [N_NODES-1:0][2:0]         msg_type_o,
  output logic [N_NODES-1:0][BLK_W-1:0]   msg_blk_o,
  output logic [N_NODES-1:0][ID_W-1:0]    msg_peer_o,
  output logic [N_NODES-1:0][DATA_W-1:0]  msg_data_o
);

  localparam logic [N_NODES-1:0] ONE = N_NODES'(1);

  logic               trk_valid, trk_excl, trk_flush, trk_done;
  logic [BLK_W-1:0]   trk_blk;
  logic [ID_W-1:0]    trk_req;
  logic [N_NODES-1:0] trk_mask;
  logic [N_NODES-1:0] pres_a;
  logic               dirty_a;
  logic [DATA_W-1:0]  data_a, data_b, grant_data;
  act_e               act;
  logic [N_NODES-1:0] others, req_bit, owner_bit, trk_req_bit;
  logic [ID_W-1:0]    owner;
  logic               busy, trk_load;

  assign busy        = trk_valid && (trk_blk == req_blk_i);
  assign req_bit     = ONE << req_node_i;
  assign owner_bit   = ONE << owner;
  assign trk_req_bit = ONE << trk_req;
  assign grant_data  = trk_flush ? ack_data_i : data_b;
  assign trk_load    = (act == ACT_INV) || (act == ACT_FWD_RD) || (act == ACT_RECALL);

  dir_decide #(.N_NODES(N_NODES), .ID_W(ID_W)) u_decide (
    .req_valid_i (req_valid_i),
    .req_node_i  (req_node_i),
    .req_excl_i  (req_excl_i),
    .pres_i      (pres_a),
    .dirty_i     (dirty_a),
    .busy_i      (busy),
    .trk_free_i  (!trk_valid),
    .act_o       (act),
    .others_o    (others),
    .owner_o     (owner)
  );

  dir_store #(
    .N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W),
    .INIT_BASE(INIT_BASE), .BLK_W(BLK_W)
  ) u_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_a_blk_i     (req_blk_i),
    .pres_a_o       (pres_a),
    .dirty_a_o      (dirty_a),
    .data_a_o       (data_a),
    .rd_b_blk_i     (trk_blk),
    .data_b_o       (data_b),
    .wr_a_en_i      ((act == ACT_DATA) || (act == ACT_GRANT)),
    .wr_a_blk_i     (req_blk_i),
    .wr_a_pres_i    ((act == ACT_DATA) ? (pres_a | req_bit) : req_bit),
    .wr_a_dirty_i   (act == ACT_GRANT),
    .wr_b_en_i      (trk_done),
    .wr_b_blk_i     (trk_blk),
    .wr_b_pres_i    (trk_excl ? trk_req_bit : (trk_mask | trk_req_bit)),
    .wr_b_dirty_i   (trk_excl),
    .wr_b_data_en_i (trk_flush),
    .wr_b_data_i    (ack_data_i)
  );

  dir_tracker #(.N_NODES(N_NODES), .ID_W(ID_W), .BLK_W(BLK_W)) u_tracker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (trk_load),
    .load_blk_i   (req_blk_i),
    .load_req_i   (req_node_i),
    .load_mask_i  ((act == ACT_INV) ? others : owner_bit),
    .load_excl_i  (act != ACT_FWD_RD),
    .load_flush_i (act != ACT_INV),
    .ack_valid_i  (ack_valid_i),
    .ack_node_i   (ack_node_i),
    .valid_o      (trk_valid),
    .blk_o        (trk_blk),
    .req_o        (trk_req),
    .mask_o       (trk_mask),
    .excl_o       (trk_excl),
    .flush_o      (trk_flush),
    .done_o       (trk_done)
  );

  logic [N_NODES-1:0][2:0]        typ_d, typ_q;
  logic [N_NODES-1:0][BLK_W-1:0]  blk_d, blk_q;
  logic [N_NODES-1:0][ID_W-1:0]   peer_d, peer_q;
  logic [N_NODES-1:0][DATA_W-1:0] dat_d, dat_q;

  always_comb begin
    for (int n = 0; n < N_NODES; n++) begin
      typ_d[n]  = MSG_NONE;
      blk_d[n]  = req_blk_i;
      peer_d[n] = req_node_i;
      dat_d[n]  = data_a;
      if (ID_W'(n) == req_node_i) begin
        case (act)
          ACT_NACK:               typ_d[n] = MSG_NACK;
          ACT_DATA:               typ_d[n] = MSG_DATA;
          ACT_GRANT, ACT_OWN_HIT: typ_d[n] = MSG_GRANT;
          ACT_FWD_RD: begin
            typ_d[n]  = MSG_OWNER;
            peer_d[n] = owner;
          end
          default: ;
        endcase
      end
      if ((act == ACT_INV) && others[n]) typ_d[n] = MSG_INV;
      if ((ID_W'(n) == owner) && (act == ACT_FWD_RD)) typ_d[n] = MSG_FWD_RD;
      if ((ID_W'(n) == owner) && (act == ACT_RECALL)) typ_d[n] = MSG_RECALL;
      // completion grant to the waiting writer
      if (trk_done && trk_excl && (ID_W'(n) == trk_req)) begin
        typ_d[n]  = MSG_GRANT;
        blk_d[n]  = trk_blk;
        peer_d[n] = trk_req;
        dat_d[n]  = grant_data;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      typ_q  <= '0;
      blk_q  <= '0;
      peer_q <= '0;
      dat_q  <= '0;
    end else begin
      typ_q  <= typ_d;
      blk_q  <= blk_d;
      peer_q <= peer_d;
      dat_q  <= dat_d;
    end
  end

  assign msg_type_o = typ_q;
  assign msg_blk_o  = blk_q;
  assign msg_peer_o = peer_q;
  assign msg_data_o = dat_q;

  AST_NACK_ON_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy) |=> (typ_q[$past(req_node_i)] == MSG_NACK)) else $error("busy block not refused"); // R9

  for (genvar n = 0; n < N_NODES; n++) begin : g_msg_chk
    AST_NO_INV_TO_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (typ_q[n] == MSG_INV) |-> (trk_valid && trk_excl && (trk_req != ID_W'(n)))) else $error("bad invalidate"); // R4
    AST_FWD_HAS_TRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (typ_q[n] == MSG_FWD_RD) |-> (trk_valid && !trk_excl)) else $error("forward without pending read"); // R6
  end

endmodule

// File: tb/dir_home_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb_top;

  localparam int N = 4, NB = 8, DW = 16, IW = 2, BW = 3;
  localparam logic [2:0] T_NONE = 3'd0, T_DATA = 3'd1, T_GRANT = 3'd2, T_OWNER = 3'd3,
                         T_FWD = 3'd4, T_RECALL = 3'd5, T_INV = 3'd6, T_NACK = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_excl = 1'b0, ack_valid = 1'b0;
  logic [IW-1:0] req_node = '0, ack_node = '0;
  logic [BW-1:0] req_blk = '0;
  logic [DW-1:0] ack_data = '0;
  logic [N-1:0][2:0]    msg_type;
  logic [N-1:0][BW-1:0] msg_blk;
  logic [N-1:0][IW-1:0] msg_peer;
  logic [N-1:0][DW-1:0] msg_data;

  always #10 clk = ~clk;

  dir_home_ctrl #(.N_NODES(N), .N_BLOCKS(NB), .DATA_W(DW), .INIT_BASE('h1000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_node_i(req_node), .req_blk_i(req_blk), .req_excl_i(req_excl),
    .ack_valid_i(ack_valid), .ack_node_i(ack_node), .ack_data_i(ack_data),
    .msg_type_o(msg_type), .msg_blk_o(msg_blk), .msg_peer_o(msg_peer), .msg_data_o(msg_data)
  );

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;

  typedef struct packed {
    logic [1:0]    rq;
    logic [IW-1:0] node;
    logic [BW-1:0] blk;
    logic          excl;
    logic [2:0]    et;
    logic [DW-1:0] ed;
  } vec_t;

  // rq: 0 -> R2, 1 -> R3, 2 -> R8
  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd0, 3'd0, 1'b0, T_DATA,  16'h1000},
    '{2'd0, 2'd1, 3'd0, 1'b0, T_DATA,  16'h1000},
    '{2'd1, 2'd2, 3'd1, 1'b1, T_GRANT, 16'h1001},
    '{2'd2, 2'd2, 3'd1, 1'b0, T_GRANT, 16'h1001},
    '{2'd1, 2'd3, 3'd2, 1'b1, T_GRANT, 16'h1002},
    '{2'd2, 2'd3, 3'd2, 1'b1, T_GRANT, 16'h1002},
    '{2'd0, 2'd1, 3'd3, 1'b0, T_DATA,  16'h1003},
    '{2'd1, 2'd1, 3'd3, 1'b1, T_GRANT, 16'h1003}
  };

  task automatic chk(input string tag, input int n, input logic [2:0] et, input int ep,
                     input int eb, input logic [DW-1:0] ed);
    bit ok;
    ok = (msg_type[n] == et);
    if (et != T_NONE && ep >= 0 && msg_peer[n] != IW'(ep)) ok = 1'b0;
    if (et != T_NONE && msg_blk[n] != BW'(eb)) ok = 1'b0;
    if ((et == T_DATA || et == T_GRANT) && msg_data[n] != ed) ok = 1'b0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s node%0d: type=%0d peer=%0d blk=%0d data=%h expected type=%0d peer=%0d blk=%0d data=%h",
               tag, n, msg_type[n], msg_peer[n], msg_blk[n], msg_data[n], et, ep, eb, ed);
    end
  endtask

  task automatic quiet(input string tag, input logic [N-1:0] mask);
    for (int n = 0; n < N; n++) if (mask[n]) chk(tag, n, T_NONE, -1, 0, '0);
  endtask

  task automatic send_req(input int n, input int b, input logic x);
    @(negedge clk);
    req_valid = 1'b1; req_node = IW'(n); req_blk = BW'(b); req_excl = x;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_ack(input int n, input logic [DW-1:0] d);
    @(negedge clk);
    ack_valid = 1'b1; ack_node = IW'(n); ack_data = d;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=still running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    quiet("R1", 4'hF);

    foreach (VECS[i]) begin
      string tg;
      tg = (VECS[i].rq == 2'd0) ? "R2" : (VECS[i].rq == 2'd1) ? "R3" : "R8";
      send_req(VECS[i].node, VECS[i].blk, VECS[i].excl);
      chk(tg, VECS[i].node, VECS[i].et, VECS[i].node, VECS[i].blk, VECS[i].ed);
      quiet(tg, ~(4'b0001 << VECS[i].node));
    end

    // R4 invalidation round on block 0 shared by nodes 0 and 1
    send_req(2, 0, 1'b1);
    chk("R4", 0, T_INV, 2, 0, '0);
    chk("R4", 1, T_INV, 2, 0, '0);
    quiet("R4", 4'b1100);
    send_req(3, 0, 1'b0);
    chk("R9", 3, T_NACK, 3, 0, '0);
    send_req(3, 4, 1'b0);
    chk("R10", 3, T_DATA, 3, 4, 16'h1004);
    send_req(3, 1, 1'b0);
    chk("R9", 3, T_NACK, 3, 1, '0);
    send_ack(3, '0);
    quiet("R4", 4'hF);
    send_ack(0, '0);
    quiet("R5", 4'hF);
    send_ack(0, '0);
    quiet("R4", 4'hF);
    send_ack(1, '0);
    chk("R5", 2, T_GRANT, 2, 0, 16'h1000);
    quiet("R4", 4'b1011);

    // R6 dirty read: owner forwards, data written home
    send_req(0, 0, 1'b0);
    chk("R3", 0, T_OWNER, 2, 0, '0);
    chk("R6", 2, T_FWD, 0, 0, '0);
    send_ack(2, 16'hBEEF);
    quiet("R6", 4'hF);
    send_req(3, 0, 1'b0);
    chk("R6", 3, T_DATA, 3, 0, 16'hBEEF);
    send_req(1, 0, 1'b1);
    chk("R6", 0, T_INV, 1, 0, '0);
    chk("R6", 2, T_INV, 1, 0, '0);
    chk("R6", 3, T_INV, 1, 0, '0);
    chk("R4", 1, T_NONE, -1, 0, '0);
    send_ack(2, '0);
    send_ack(3, '0);
    chk("R5", 1, T_NONE, -1, 0, '0);
    send_ack(0, '0);
    chk("R4", 1, T_GRANT, 1, 0, 16'hBEEF);

    // R7 write to block dirty elsewhere
    send_req(3, 0, 1'b1);
    chk("R7", 1, T_RECALL, 3, 0, '0);
    quiet("R7", 4'b1101);
    send_ack(1, 16'h5A5A);
    chk("R7", 3, T_GRANT, 3, 0, 16'h5A5A);
    send_req(0, 0, 1'b0);
    chk("R11", 0, T_OWNER, 3, 0, '0);
    chk("R6", 3, T_FWD, 0, 0, '0);
    send_ack(3, 16'h7777);
    send_req(2, 0, 1'b0);
    chk("R6", 2, T_DATA, 2, 0, 16'h7777);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule